// File: doc/BRIEF.md
# Two-Channel Quadrature Position Counter

This block tracks the position of two rotary or linear encoders. Each channel takes an A/B phase pair and first synchronizes it to the block clock. It then decodes every legal phase transition into a single up or down step of an 8-bit position counter. The counter wraps modulo 256, and the current value of each counter appears on its own output.

A single 8-bit register serves both channels. When a counter wraps, a sticky flag for that channel and direction is set. Reading the register returns the flags and clears them. A single level interrupt stays high while any flag is set. Writing the register can zero either counter on its own. Such a write never sets a flag and never raises the interrupt.

Top module: `qdec_dual`

## Requirements
- R1: While rst_ni is low and after it rises, both counters read 0x00, the register reads 0x00 and irq_o is low.
- R2: The phase state is {A,B}. The sequence 00→01→11→10→00 counts up by one per step, and the reverse sequence counts down by one per step. A change on the inputs shows up on the count output after the third rising clock edge.
- R3: A jump that changes both A and B at once (00↔11, 01↔10) leaves the counter unchanged.
- R4: An up step from 0xFF to 0x00 sets the up-wrap flag. This is register bit 3 for channel 0 and bit 7 for channel 1.
- R5: A down step from 0x00 to 0xFF sets the down-wrap flag. This is register bit 2 for channel 0 and bit 6 for channel 1.
- R6: irq_o is the OR of the four wrap flags. It rises in the same cycle as the flag that causes it and stays high until a read clears it.
- R7: While reg_rd_i is high, reg_rdata_o shows the flags. At the clock edge that ends the read, all flags clear, and irq_o falls with them.
- R8: A wrap that happens on the same clock edge as a read leaves its flag set after the read.
- R9: Writing 1 to bit 0 zeroes counter 0, and writing 1 to bit 4 zeroes counter 1, at the next edge. Neither write sets a flag or changes irq_o. Writing 0 to these bits has no effect.
- R10: Bits 5, 4, 1 and 0 of reg_rdata_o always read 0.
- R11: Motion on one channel never changes the other channel's counter or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 2 | Phase A, one bit per channel |
| enc_b_i | input | 2 | Phase B, one bit per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data (bit 0 and bit 4 zero a counter) |
| reg_rd_i | input | 1 | Register read strobe, clears flags |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Wrap interrupt, level high |
| count0_o | output | 8 | Channel 0 position |
| count1_o | output | 8 | Channel 1 position |

## Verification
Directed stimulus walks the Gray sequence in both directions, which separates a correct direction decode from a swapped one. Diagonal jumps show that an illegal transition is dropped rather than counted. Counts are driven across 0xFF/0x00 both ways to tell up-wrap from down-wrap flags and to time the interrupt against the flag. A read is aligned to the same edge as a wrap to catch a lost event. A random mix of legal steps, illegal jumps, reads and clearing writes on both channels then checks that the channels stay independent.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int NUM_CH = 2;
  localparam int REG_W  = 8;

  typedef enum logic [1:0] {MV_NONE, MV_UP, MV_DN, MV_BAD} move_e;

  // per-channel bit positions in the shared register
  function automatic int up_bit(int ch);  return 4*ch + 3; endfunction
  function automatic int dn_bit(int ch);  return 4*ch + 2; endfunction
  function automatic int clr_bit(int ch); return 4*ch;     endfunction

  // Gray phase code to position index: 00,01,11,10 -> 0,1,2,3
  function automatic logic [1:0] gray2idx(logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ab_i,
  output move_e      move_o
);
  logic [1:0] prev_q;
  logic [1:0] delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b00;
    else         prev_q <= ab_i;
  end

  assign delta = gray2idx(ab_i) - gray2idx(prev_q);

  always_comb begin
    unique case (delta)
      2'd1:    move_o = MV_UP;
      2'd3:    move_o = MV_DN;
      2'd2:    move_o = MV_BAD;  // both phases flipped: dropped
      default: move_o = MV_NONE;
    endcase
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_up_o,
  output logic         wrap_dn_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (up_i)  cnt_q <= cnt_q + 1'b1;
    else if (dn_i)  cnt_q <= cnt_q - 1'b1;
  end

  // clear takes priority and suppresses wrap events
  assign wrap_up_o = !clr_i && up_i && (cnt_q == '1);
  assign wrap_dn_o = !clr_i && dn_i && (cnt_q == '0);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/qdec_dual.sv
module qdec_dual
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       enc_a_i,
  input  logic [1:0]       enc_b_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             reg_rd_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] count0_o,
  output logic [CNT_W-1:0] count1_o
);
  logic [CNT_W-1:0]  cnt   [NUM_CH];
  logic [NUM_CH-1:0] st_up_q, st_dn_q;
  logic [NUM_CH-1:0] ev_up, ev_dn;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[7:5], reg_wdata_i[3:1]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0] ab_s;
    move_e      mv;
    logic       clr;

    qdec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({enc_a_i[c], enc_b_i[c]}),
      .q_o   (ab_s)
    );

    qdec_step u_step (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ab_i  (ab_s),
      .move_o(mv)
    );

    assign clr = reg_wr_i && reg_wdata_i[clr_bit(c)];

    qdec_counter #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .up_i     (mv == MV_UP),
      .dn_i     (mv == MV_DN),
      .cnt_o    (cnt[c]),
      .wrap_up_o(ev_up[c]),
      .wrap_dn_o(ev_dn[c])
    );
  end

  // sticky flags: read clears, same-edge events win
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_up_q <= '0;
      st_dn_q <= '0;
    end else begin
      st_up_q <= (reg_rd_i ? '0 : st_up_q) | ev_up;
      st_dn_q <= (reg_rd_i ? '0 : st_dn_q) | ev_dn;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      reg_rdata_o[up_bit(c)] = st_up_q[c];
      reg_rdata_o[dn_bit(c)] = st_dn_q[c];
    end
  end

  assign irq_o    = |{st_up_q, st_dn_q};
  assign count0_o = cnt[0];
  assign count1_o = cnt[1];
endmodule

// File: rtl/qdec_dual_chk.sv
module qdec_dual_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [7:0]       reg_wdata_i,
  input logic             reg_rd_i,
  input logic [7:0]       reg_rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] count0_o,
  input logic [CNT_W-1:0] count1_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (count0_o == '0 && count1_o == '0 && !irq_o && reg_rdata_o == '0));

  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_wr_i && reg_wdata_i[0]) |->
      (count0_o == $past(count0_o) || count0_o == $past(count0_o) + ONE
       || count0_o == $past(count0_o) - ONE));

  a_r4_up_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(count0_o) == '1 && count0_o == '0 && !$past(reg_wr_i && reg_wdata_i[0]))
      |-> reg_rdata_o[3]);

  a_r4_up_wrap_flag_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(count1_o) == '1 && count1_o == '0 && !$past(reg_wr_i && reg_wdata_i[4]))
      |-> reg_rdata_o[7]);

  a_r5_dn_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(count0_o) == '0 && count0_o == '1) |-> (reg_rdata_o[2] && irq_o));

  a_r6_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_rd_i) |=> irq_o);

  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> (($stable(count0_o) && $stable(count1_o)) -> !irq_o));

  a_r9_clear_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[0]) |=> count0_o == '0);

  a_r9_clear_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[0] && reg_wdata_i[4] && !irq_o) |=> !irq_o);

  a_r10_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[5:4] == 2'b00 && reg_rdata_o[1:0] == 2'b00);
endmodule

bind qdec_dual qdec_dual_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rd_i   (reg_rd_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .count0_o   (count0_o),
  .count1_o   (count1_o)
);

// File: tb/sim_qdec_dual.sv
`timescale 1ns/1ps
module sim_qdec_dual;
  localparam int TCK = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] enc_a = '0, enc_b = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic [7:0] cnt0, cnt1;

  int n_chk = 0, n_bad = 0;

  logic [7:0] m_cnt [2];
  logic [7:0] m_st;
  logic [1:0] m_ab [2];

  always #(TCK/2) clk = ~clk;

  qdec_dual u0 (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .irq_o(irq), .count0_o(cnt0), .count1_o(cnt1)
  );

  function automatic logic [1:0] g2i(logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  function automatic logic [1:0] next_ab(logic [1:0] ab, bit up);
    logic [1:0] i = g2i(ab) + (up ? 2'd1 : 2'd3);
    return {i[1], i[1] ^ i[0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(cnt0 == m_cnt[0], {req, " cnt0"}, cnt0, m_cnt[0]);
    chk(cnt1 == m_cnt[1], {req, " cnt1"}, cnt1, m_cnt[1]);
    chk(rdata == m_st, {req, " flags"}, rdata, m_st);
    chk(irq == (m_st != 0), "R6 irq", irq, m_st != 0);
    chk((rdata & 8'h33) == 0, "R10 zero bits", rdata, rdata & 8'hCC);
  endtask

  // model one phase change; updates flags for wraps
  task automatic model_move(int ch, logic [1:0] ab);
    logic [1:0] d = g2i(ab) - g2i(m_ab[ch]);
    if (d == 2'd1) begin
      if (m_cnt[ch] == 8'hFF) m_st[4*ch+3] = 1'b1;
      m_cnt[ch]++;
    end else if (d == 2'd3) begin
      if (m_cnt[ch] == 8'h00) m_st[4*ch+2] = 1'b1;
      m_cnt[ch]--;
    end
    m_ab[ch] = ab;
  endtask

  task automatic drive_ab(int ch, logic [1:0] ab);
    enc_a[ch] = ab[1];
    enc_b[ch] = ab[0];
  endtask

  task automatic move(int ch, logic [1:0] ab, string req);
    drive_ab(ch, ab);
    model_move(ch, ab);
    repeat (4) @(negedge clk);
    chk_all(req);
  endtask

  task automatic step(int ch, bit up, int n, string req);
    for (int i = 0; i < n; i++) move(ch, next_ab(m_ab[ch], up), req);
  endtask

  task automatic rd_reg();
    rd = 1'b1;
    chk(rdata == m_st, "R7 read data", rdata, m_st);
    @(negedge clk);
    rd = 1'b0;
    m_st = '0;
    chk(irq == 1'b0, "R7 irq cleared", irq, 0);
    chk(rdata == 8'h00, "R7 flags cleared", rdata, 0);
  endtask

  task automatic wr_reg(logic [7:0] d);
    wr = 1'b1;
    wdata = d;
    @(negedge clk);
    wr = 1'b0;
    wdata = '0;
    if (d[0]) m_cnt[0] = '0;
    if (d[4]) m_cnt[1] = '0;
    chk_all("R9 write clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0D1A_C0DE));
    m_cnt[0] = '0; m_cnt[1] = '0; m_st = '0; m_ab[0] = '0; m_ab[1] = '0;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1 after reset");

    // R2: up and down Gray walks; latency check
    drive_ab(0, 2'b01);
    model_move(0, 2'b01);
    @(negedge clk); @(negedge clk);
    chk(cnt0 == 8'd0, "R2 latency before", cnt0, 0);
    @(negedge clk);
    chk(cnt0 == 8'd1, "R2 latency after", cnt0, 1);
    step(0, 1'b1, 5, "R2 up");
    step(0, 1'b0, 3, "R2 down");

    // R3: diagonal jumps ignored
    move(0, ~m_ab[0], "R3 illegal");
    move(0, ~m_ab[0], "R3 illegal back");

    // R5/R6: down wrap on ch0 with per-cycle irq timing
    wr_reg(8'h01);
    begin
      logic [1:0] ab = next_ab(m_ab[0], 1'b0);
      drive_ab(0, ab);
      model_move(0, ab);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(irq == (cnt0 == 8'hFF), "R6 irq with flag", irq, cnt0 == 8'hFF);
      end
      chk_all("R5 down wrap");
    end
    rd_reg();

    // R4: up wrap
    step(0, 1'b1, 1, "R4 up wrap");
    rd_reg();

    // R11: ch1 independent
    step(1, 1'b0, 2, "R11 ch1 down");
    step(1, 1'b1, 3, "R11 ch1 up");
    rd_reg();

    // R9: writing zeros leaves counts; ch1 clear only; clear at FF no irq
    step(0, 1'b1, 2, "R9 setup");
    wr_reg(8'hEE);
    wr_reg(8'h10);
    step(1, 1'b0, 1, "R9 ch1 to FF");
    rd_reg();
    wr_reg(8'h11);
    chk(irq == 1'b0, "R9 no irq on clear", irq, 0);

    // R8: wrap on same edge as read
    step(1, 1'b0, 1, "R8 prior flag");
    begin
      logic [1:0] ab = next_ab(m_ab[0], 1'b0);
      drive_ab(0, ab);
      @(negedge clk); @(negedge clk);
      rd = 1'b1;
      chk(rdata == m_st, "R8 read data", rdata, m_st);
      @(negedge clk);
      rd = 1'b0;
      m_st = '0;
      model_move(0, ab);
      repeat (2) @(negedge clk);
      chk_all("R8 event kept");
    end
    rd_reg();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom % 12);
      int ch = int'($urandom % 2);
      if (r == 0) rd_reg();
      else if (r == 1) wr_reg(8'($urandom));
      else if (r == 2) move(ch, ~m_ab[ch], "R3 random illegal");
      else if (r < 7) step(ch, 1'b1, 1, "R11 random up");
      else step(ch, 1'b0, 1, "R11 random down");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule